// File: doc/BRIEF.md
# Command/Indicate Channel Debounced Transceiver

This block handles the four-bit command/indicate field that a time-division line interface carries once in every frame. On the receive side it collects the field bit by bit in the slots marked by a slot-enable input, most significant bit first. A new code is passed to the consumer only once the same value has arrived in two frames in a row. When that happens, the block updates a stable code register and raises a change strobe for one clock. The consumer is the activation and loopback logic that sits outside this block.

On the transmit side the block takes a code from a register input at each frame sync. It shifts that code out on the same slot positions, bit 3 first. The same code goes out in every frame until the register input changes. All pins are plain control and status signals clocked by the bit clock. There is no stream interface, so no back-pressure applies: the change strobe is a single-cycle event that the consumer must take when it occurs.

Top module: `ci_link`

## Requirements
- R1: After reset, `code_out` is 4'b1111, `code_chg` is 0 and `tx_bit` is 1.
- R2: Within a frame, the first slot-enabled cycle carries code bit 3 on `rx_bit`, and the following slots carry bits 2, 1 and 0 in that order.
- R3: A received code whose value differs from `code_out` is accepted only when the frame just before it delivered the same value. After a single frame, `code_out` keeps its old value.
- R4: When a code is accepted, `code_chg` is high for exactly one clock, and `code_out` takes the new value in that same cycle. `code_out` never changes in any other cycle.
- R5: A received code that differs from the previous frame's code becomes the new candidate and restarts confirmation. A stream that alternates between two values therefore never changes `code_out`.
- R6: Receiving the code already held in `code_out`, in any number of frames, raises no strobe.
- R7: In slot k (k = 0..3) after a frame sync, `tx_bit` equals bit 3-k of the transmit code. Outside slot-enabled cycles, `tx_bit` is 1.
- R8: The transmit code is captured from `tx_code` in the cycle `frame_sync` is high. Changing `tx_code` later in the frame does not alter the bits sent in that frame.
- R9: Slot-enabled cycles beyond the fourth in a frame are ignored: they do not affect the received code, and `tx_bit` is 1 during them.
- R10: A frame sync discards a partially received field. A frame with fewer than four slots neither counts as a frame nor disturbs the pending candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | Start of frame, one bit clock wide |
| slot_en | input | 1 | Marks a command/indicate bit slot |
| rx_bit | input | 1 | Serial receive data |
| tx_code | input | 4 | Code to transmit, sampled at frame sync |
| tx_bit | output | 1 | Serial transmit data, 1 when idle |
| code_out | output | 4 | Last accepted (debounced) code |
| code_chg | output | 1 | One-cycle strobe on acceptance |

## Verification
The embedded properties check on every clock that the strobe lasts exactly one cycle, and that `code_out` moves only together with the strobe and only to a new value. They also check that every acceptance follows a matching candidate, that the bit position never runs past four, and that the transmit shifter loads exactly at frame sync and sends 1 outside its slots. Only the bench scenarios can show which sequence of frames is needed to accept a code. These include alternating codes, repeats of the stable value, partial frames, surplus slots and a transmit code rewritten in mid-frame. The bench predicts the results with its own model of candidate and stable state.

// File: rtl/ci_pkg.sv
`timescale 1ns/1ps
package ci_pkg;
  localparam int unsigned CI_W = 4;
  localparam logic [CI_W-1:0] CI_IDLE = '1;
  typedef logic [CI_W-1:0] ci_code_t;
endpackage

// File: rtl/ci_rx_shift.sv
`timescale 1ns/1ps
module ci_rx_shift #(
  parameter int unsigned W = ci_pkg::CI_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_sync,
  input  logic         slot_en,
  input  logic         rx_bit,
  output logic [W-1:0] field,
  output logic         field_vld
);
  localparam int unsigned PW = $clog2(W + 1);
  localparam logic [PW-1:0] LAST = PW'(W - 1);
  localparam logic [PW-1:0] FULL = PW'(W);

  logic [W-1:0]  sh;
  logic [PW-1:0] pos;
  logic          take;

  assign take = slot_en && !frame_sync && (pos < FULL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh        <= '1;
      pos       <= '0;
      field     <= '1;
      field_vld <= 1'b0;
    end else begin
      field_vld <= 1'b0;
      if (frame_sync) begin
        pos <= '0;
      end else if (take) begin
        sh  <= {sh[W-2:0], rx_bit};
        pos <= pos + 1'b1;
        if (pos == LAST) begin
          field     <= {sh[W-2:0], rx_bit};
          field_vld <= 1'b1;
        end
      end
    end
  end

  p_pos_bound_r9: assert property (@(posedge clk) disable iff (!rst_n) pos <= FULL);
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (pos == '0 && !field_vld));
endmodule

// File: rtl/ci_debounce.sv
`timescale 1ns/1ps
module ci_debounce #(
  parameter int unsigned W = ci_pkg::CI_W,
  parameter logic [W-1:0] IDLE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] field,
  input  logic         field_vld,
  output logic [W-1:0] stable,
  output logic         chg
);
  logic [W-1:0] cand;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand   <= IDLE;
      stable <= IDLE;
      chg    <= 1'b0;
    end else begin
      chg <= 1'b0;
      if (field_vld) begin
        if (field != cand) begin
          cand <= field;
        end else if (field != stable) begin
          stable <= field;
          chg    <= 1'b1;
        end
      end
    end
  end

  p_strobe_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n) chg |=> !chg);
  p_only_on_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stable != $past(stable)) |-> chg);
  p_new_value_r6: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (stable != $past(stable)));
  p_confirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> ($past(field_vld) && $past(field) == $past(cand)));
endmodule

// File: rtl/ci_tx_shift.sv
`timescale 1ns/1ps
module ci_tx_shift #(
  parameter int unsigned W = ci_pkg::CI_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_sync,
  input  logic         slot_en,
  input  logic [W-1:0] tx_code,
  output logic         tx_bit
);
  localparam int unsigned PW = $clog2(W + 1);
  localparam logic [PW-1:0] FULL = PW'(W);

  logic [W-1:0]  sh;
  logic [PW-1:0] pos;
  logic          live;

  assign live   = slot_en && !frame_sync && (pos < FULL);
  assign tx_bit = live ? sh[W-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      pos <= FULL;
    end else if (frame_sync) begin
      sh  <= tx_code;
      pos <= '0;
    end else if (live) begin
      sh  <= {sh[W-2:0], 1'b1};
      pos <= pos + 1'b1;
    end
  end

  p_load_at_sync_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (sh == $past(tx_code)));
  p_idle_high_r7: assert property (@(posedge clk) disable iff (!rst_n) !slot_en |-> tx_bit);
endmodule

// File: rtl/ci_link.sv
`timescale 1ns/1ps
module ci_link #(
  parameter int unsigned W = ci_pkg::CI_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_sync,
  input  logic         slot_en,
  input  logic         rx_bit,
  input  logic [W-1:0] tx_code,
  output logic         tx_bit,
  output logic [W-1:0] code_out,
  output logic         code_chg
);
  logic [W-1:0] field;
  logic         field_vld;

  ci_rx_shift #(.W(W)) u_rx (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_en(slot_en),
    .rx_bit(rx_bit), .field(field), .field_vld(field_vld));

  ci_debounce #(.W(W), .IDLE({W{1'b1}})) u_deb (
    .clk(clk), .rst_n(rst_n), .field(field), .field_vld(field_vld),
    .stable(code_out), .chg(code_chg));

  ci_tx_shift #(.W(W)) u_tx (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_en(slot_en),
    .tx_code(tx_code), .tx_bit(tx_bit));

  p_reset_state_r1: assert property (@(posedge clk) !rst_n |=> (code_out == '1 && !code_chg));
endmodule

// File: tb/ci_link_bench.sv
`timescale 1ns/1ps
module ci_link_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_sync = 1'b0, slot_en = 1'b0, rx_bit = 1'b1;
  logic [3:0] tx_code = 4'hF;
  logic tx_bit, code_chg;
  logic [3:0] code_out;

  int n_run = 0, n_fail = 0, n_strobe = 0;
  bit done = 1'b0;
  logic [3:0] m_cand = 4'hF, m_stable = 4'hF;

  always #4 clk = ~clk;

  ci_link u_ci_link (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .slot_en(slot_en),
    .rx_bit(rx_bit), .tx_code(tx_code), .tx_bit(tx_bit),
    .code_out(code_out), .code_chg(code_chg));

  always @(negedge clk) if (rst_n && code_chg) n_strobe++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bench model: returns 1 when an acceptance is expected
  function automatic bit model_frame(input logic [3:0] c);
    if (c != m_cand) begin
      m_cand = c;
      return 1'b0;
    end
    if (c != m_stable) begin
      m_stable = c;
      return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic run_frame(input logic [3:0] c, input int nslots, input string req);
    logic [3:0] txe;
    logic [3:0] txg;
    int s0;
    bit ok_tx;
    bit exp_chg;
    s0 = n_strobe;
    ok_tx = 1'b1;
    @(negedge clk);
    frame_sync = 1'b1;
    txe = tx_code;
    @(negedge clk);
    frame_sync = 1'b0;
    tx_code = 4'($urandom);   // mid-frame rewrite (R8)
    #1 check(tx_bit == 1'b1, "R7 idle", tx_bit, 1);
    for (int k = 0; k < nslots; k++) begin
      if ($urandom_range(1, 0) == 1) @(negedge clk);
      slot_en = 1'b1;
      rx_bit = (k < 4) ? c[3-k] : 1'($urandom);
      #1;
      if (k < 4) txg[3-k] = tx_bit;
      else if (tx_bit != 1'b1) ok_tx = 1'b0;
      @(negedge clk);
      slot_en = 1'b0;
      rx_bit = 1'b1;
    end
    repeat (3) @(negedge clk);
    if (nslots >= 4) begin
      check(ok_tx && txg == txe, "R7/R8/R9 tx", txg, txe);
      exp_chg = model_frame(c);
    end else begin
      exp_chg = 1'b0;
    end
    check(code_out == m_stable, req, code_out, m_stable);
    check((n_strobe - s0) == int'(exp_chg), {req, " strobe"}, n_strobe - s0, int'(exp_chg));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    check(code_out == 4'hF, "R1 code", code_out, 15);
    check(code_chg == 1'b0, "R1 strobe", code_chg, 0);
    check(tx_bit == 1'b1, "R1 tx", tx_bit, 1);
    rst_n = 1'b1;
    tx_code = 4'hA;
    run_frame(4'h6, 4, "R3 single");        // no change yet
    run_frame(4'h6, 4, "R2 R3 R4 confirm"); // 0110 MSB first
    run_frame(4'h6, 4, "R6 repeat");
    run_frame(4'h6, 4, "R6 repeat2");
    for (int i = 0; i < 4; i++)
      run_frame((i % 2) ? 4'h3 : 4'hC, 4, "R5 alternate");
    run_frame(4'h9, 4, "R10 cand");
    run_frame(4'h2, 2, "R10 partial");
    run_frame(4'h9, 4, "R10 accept");
    run_frame(4'h1, 6, "R9 extra a");
    run_frame(4'h1, 6, "R9 extra b");
    run_frame(4'hE, 4, "R2 order a");
    run_frame(4'h7, 4, "R2 order b");
    for (int i = 0; i < 300; i++) begin
      logic [3:0] c;
      c = ($urandom_range(2, 0) == 0) ? 4'($urandom) : m_cand;
      run_frame(c, ($urandom_range(9, 0) == 0) ? 5 : 4, "R3/R4/R5 random");
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule